// File: doc/BRIEF.md
# UART Interrupt Source Identifier

This block gathers every interrupt condition of one UART channel, masks each one with an enable vector, and picks the most urgent one. It reports that source as a 6-bit identification code and raises an interrupt request whenever at least one enabled source is pending. The code and the request are combinational from the held state and the level inputs, so they are recomputed in every cycle.

Three of the sources are levels owned by the receive path: a line status error, a receive timeout, and receive data at the trigger level. The block follows these levels and holds no state for them. The other sources arrive as one-cycle event pulses and are held in sticky bits: transmit holding register empty, the modem status deltas, special character detected, and a change on the flow-control pins. Each sticky bit has its own clearing rule. A read of the identification code clears only the source that the read reports. A write to the transmit holding register clears the transmit-empty source. A read of the modem status clears the modem deltas.

Top module: `uartIrqId`

## Requirements
- R1: While reset is held and right after it is released, intId is 0x01, irq is 0 and modemDelta is all zero.
- R2: intId bit 0 is 1 exactly when no enabled source is pending. irq is its inverse and follows the inputs in the same cycle.
- R3: The codes are line status error 0x06, receive timeout 0x0C, receive data 0x04, transmit empty 0x02, modem change 0x00, special character 0x10 and flow-pin change 0x20.
- R4: When several enabled sources are pending, the code reports the first of this ranking: line status error, timeout, receive data, transmit empty, modem change, special character, flow-pin change.
- R5: The enable bits are bit 0 for receive data and timeout, bit 1 for transmit empty, bit 2 for line status, bit 3 for modem change, bit 4 for special character and bit 5 for flow-pin change. A disabled source affects neither intId nor irq, but its sticky state is kept and shows once the source is enabled.
- R6: A transmit-empty pulse makes the source pending from the next cycle. The source clears in the cycle after an identification read that reports 0x02, or after a transmit holding register write.
- R7: Each modem event pulse sets its own modemDelta bit from the next cycle. A modem status read clears all of these bits in the next cycle.
- R8: The special-character source clears in the cycle after an identification read that reports 0x10.
- R9: The flow-pin change source clears in the cycle after an identification read that reports 0x20.
- R10: An identification read clears no sticky source other than the one it reports.
- R11: Line status, timeout and receive data are not latched. They stop showing as soon as their input falls.
- R12: When a set pulse and a clear arrive in the same cycle for a sticky source, the source ends up pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineErr | input | 1 | Level: receiver line status error present |
| rxTimeout | input | 1 | Level: receive character timeout |
| rxTrig | input | 1 | Level: receive FIFO at trigger level |
| thrEmptyEvt | input | 1 | Pulse: transmit holding register became empty |
| modemEvt | input | MDM_W | Pulses: per-line modem status change |
| specialEvt | input | 1 | Pulse: special character received |
| flowEvt | input | 1 | Pulse: flow-control pin changed |
| intEnable | input | 6 | Per-source enable vector |
| idRead | input | 1 | Strobe: identification code is being read |
| thrWrite | input | 1 | Strobe: transmit holding register written |
| msrRead | input | 1 | Strobe: modem status being read |
| irq | output | 1 | Interrupt request |
| intId | output | 6 | Identification code of the top-ranked pending source |
| modemDelta | output | MDM_W | Sticky modem change bits |

## Verification
The hardest case to reach is a read that must clear only the source it reports while other sticky sources are still latched underneath it. The read has to land in a cycle where a higher-ranked source, or a narrower enable vector, makes a chosen source the one reported. The bench builds these stacks on purpose. It latches several events, steers the reported source with a line-error level or by clearing enable bits, and then reads. It also sends a set pulse and its matching clear in the same cycle. A behavioural model compares the code, the request and the modem bits on every clock.

// File: rtl/uartIrqPkg.sv
package uartIrqPkg;

  localparam int EN_W = 6;

  // Enable vector bit positions.
  localparam int EN_RX   = 0;
  localparam int EN_THR  = 1;
  localparam int EN_LINE = 2;
  localparam int EN_MDM  = 3;
  localparam int EN_SPC  = 4;
  localparam int EN_FLOW = 5;

  // Sources in rank order: a lower value wins.
  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_LINE = 3'd1,
    SRC_TMO  = 3'd2,
    SRC_RXD  = 3'd3,
    SRC_THR  = 3'd4,
    SRC_MDM  = 3'd5,
    SRC_SPC  = 3'd6,
    SRC_FLOW = 3'd7
  } srcT;

  localparam int NUM_RANK = 7;

  // Indices of the sticky bits inside the datapath.
  localparam int STK_THR  = 0;
  localparam int STK_SPC  = 1;
  localparam int STK_FLOW = 2;
  localparam int NUM_STK  = 3;

  typedef struct packed {
    logic clrThr;
    logic clrSpc;
    logic clrFlow;
    logic clrMdm;
  } clrStrobeT;

  function automatic logic [5:0] codeOf(srcT s);
    case (s)
      SRC_LINE: codeOf = 6'h06;
      SRC_TMO:  codeOf = 6'h0C;
      SRC_RXD:  codeOf = 6'h04;
      SRC_THR:  codeOf = 6'h02;
      SRC_MDM:  codeOf = 6'h00;
      SRC_SPC:  codeOf = 6'h10;
      SRC_FLOW: codeOf = 6'h20;
      default:  codeOf = 6'h01;
    endcase
  endfunction

endpackage

// File: rtl/uartIrqDatapath.sv
module uartIrqDatapath
  import uartIrqPkg::*;
#(
  parameter int MDM_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                lineErr,
  input  logic                rxTimeout,
  input  logic                rxTrig,
  input  logic                thrEmptyEvt,
  input  logic [MDM_W-1:0]    modemEvt,
  input  logic                specialEvt,
  input  logic                flowEvt,
  input  logic [EN_W-1:0]     intEnable,
  input  clrStrobeT           clr,
  output srcT                 winner,
  output logic [MDM_W-1:0]    modemDelta
);

  logic [NUM_STK-1:0] stkSet, stkClr, stkQ;

  assign stkSet[STK_THR]  = thrEmptyEvt;
  assign stkSet[STK_SPC]  = specialEvt;
  assign stkSet[STK_FLOW] = flowEvt;
  assign stkClr[STK_THR]  = clr.clrThr;
  assign stkClr[STK_SPC]  = clr.clrSpc;
  assign stkClr[STK_FLOW] = clr.clrFlow;

  // Sticky sources: a set pulse overrides a clear in the same cycle.
  for (genvar g = 0; g < NUM_STK; g++) begin : gSticky
    always_ff @(posedge clk) begin
      if (!rstN) stkQ[g] <= 1'b0;
      else       stkQ[g] <= stkSet[g] | (stkQ[g] & ~stkClr[g]);
    end
  end

  logic [MDM_W-1:0] mdmQ;
  always_ff @(posedge clk) begin
    if (!rstN) mdmQ <= '0;
    else       mdmQ <= modemEvt | (clr.clrMdm ? '0 : mdmQ);
  end
  assign modemDelta = mdmQ;

  // Masked pending flags, indexed by rank.
  logic [NUM_RANK:1] pendRank;
  always_comb begin
    pendRank                = '0;
    pendRank[int'(SRC_LINE)] = lineErr        & intEnable[EN_LINE];
    pendRank[int'(SRC_TMO)]  = rxTimeout      & intEnable[EN_RX];
    pendRank[int'(SRC_RXD)]  = rxTrig         & intEnable[EN_RX];
    pendRank[int'(SRC_THR)]  = stkQ[STK_THR]  & intEnable[EN_THR];
    pendRank[int'(SRC_MDM)]  = (|mdmQ)        & intEnable[EN_MDM];
    pendRank[int'(SRC_SPC)]  = stkQ[STK_SPC]  & intEnable[EN_SPC];
    pendRank[int'(SRC_FLOW)] = stkQ[STK_FLOW] & intEnable[EN_FLOW];
  end

  // Scan from the lowest rank upward so the highest one wins.
  always_comb begin
    winner = SRC_NONE;
    for (int i = NUM_RANK; i >= 1; i--) begin
      if (pendRank[i]) winner = srcT'(3'(i));
    end
  end

  AST_THR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    stkQ[STK_THR] && !clr.clrThr |=> stkQ[STK_THR]); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    specialEvt && clr.clrSpc |=> stkQ[STK_SPC]); // R12
  AST_MDM_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    clr.clrMdm && (modemEvt == '0) |=> (modemDelta == '0)); // R7
  AST_LINE_TOP: assert property (@(posedge clk) disable iff (!rstN)
    lineErr && intEnable[EN_LINE] |-> winner == SRC_LINE); // R4
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (intEnable == '0) |-> winner == SRC_NONE); // R5

endmodule

// File: rtl/uartIrqCtrl.sv
module uartIrqCtrl
  import uartIrqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       idRead,
  input  logic       thrWrite,
  input  logic       msrRead,
  input  srcT        winner,
  output clrStrobeT  clr,
  output logic [5:0] intId,
  output logic       irq
);

  always_comb begin
    clr.clrThr  = thrWrite | (idRead && winner == SRC_THR);
    clr.clrSpc  = idRead && winner == SRC_SPC;
    clr.clrFlow = idRead && winner == SRC_FLOW;
    clr.clrMdm  = msrRead;
  end

  assign intId = codeOf(winner);
  assign irq   = (winner != SRC_NONE);

  AST_ONE_READ_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    idRead |-> $onehot0({clr.clrSpc, clr.clrFlow, clr.clrThr & ~thrWrite})); // R10
  AST_ID_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> !intId[0]); // R2

endmodule

// File: rtl/uartIrqId.sv
module uartIrqId
  import uartIrqPkg::*;
#(
  parameter int MDM_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineErr,
  input  logic             rxTimeout,
  input  logic             rxTrig,
  input  logic             thrEmptyEvt,
  input  logic [MDM_W-1:0] modemEvt,
  input  logic             specialEvt,
  input  logic             flowEvt,
  input  logic [5:0]       intEnable,
  input  logic             idRead,
  input  logic             thrWrite,
  input  logic             msrRead,
  output logic             irq,
  output logic [5:0]       intId,
  output logic [MDM_W-1:0] modemDelta
);

  srcT       winner;
  clrStrobeT clr;

  uartIrqDatapath #(.MDM_W(MDM_W)) uDp (
    .clk(clk), .rstN(rstN),
    .lineErr(lineErr), .rxTimeout(rxTimeout), .rxTrig(rxTrig),
    .thrEmptyEvt(thrEmptyEvt), .modemEvt(modemEvt),
    .specialEvt(specialEvt), .flowEvt(flowEvt),
    .intEnable(intEnable), .clr(clr),
    .winner(winner), .modemDelta(modemDelta)
  );

  uartIrqCtrl uCtrl (
    .clk(clk), .rstN(rstN),
    .idRead(idRead), .thrWrite(thrWrite), .msrRead(msrRead),
    .winner(winner), .clr(clr), .intId(intId), .irq(irq)
  );

endmodule

// File: tb/tb_uartIrqId.sv
module tb_uartIrqId;

  localparam int MDM_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineErr = 0, rxTimeout = 0, rxTrig = 0, thrEmptyEvt = 0;
  logic [MDM_W-1:0] modemEvt = '0;
  logic specialEvt = 0, flowEvt = 0;
  logic [5:0] intEnable = '0;
  logic idRead = 0, thrWrite = 0, msrRead = 0;
  logic irq;
  logic [5:0] intId;
  logic [MDM_W-1:0] modemDelta;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uartIrqId #(.MDM_W(MDM_W)) dut (
    .clk(clk), .rstN(rstN), .lineErr(lineErr), .rxTimeout(rxTimeout),
    .rxTrig(rxTrig), .thrEmptyEvt(thrEmptyEvt), .modemEvt(modemEvt),
    .specialEvt(specialEvt), .flowEvt(flowEvt), .intEnable(intEnable),
    .idRead(idRead), .thrWrite(thrWrite), .msrRead(msrRead),
    .irq(irq), .intId(intId), .modemDelta(modemDelta)
  );

  // Behavioural reference model
  bit mThr, mSpc, mFlow, nThr, nSpc, nFlow;
  int mDelta, nDelta;

  function automatic int expCode();
    if (lineErr && intEnable[2])                   return 'h06;
    if (rxTimeout && intEnable[0])                 return 'h0C;
    if (rxTrig && intEnable[0])                    return 'h04;
    if (mThr && intEnable[1])                      return 'h02;
    if (mDelta != 0 && intEnable[3])               return 'h00;
    if (mSpc && intEnable[4])                      return 'h10;
    if (mFlow && intEnable[5])                     return 'h20;
    return 'h01;
  endfunction

  always @(negedge clk) begin
    if (!rstN) begin
      nThr = 0; nSpc = 0; nFlow = 0; nDelta = 0;
    end else begin
      automatic int c = expCode();
      automatic bit eIrq = (c != 'h01);
      nChecks++;
      if (int'(intId) != c) begin
        nFails++;
        $display("FAIL R4 model intId actual=%02h expected=%02h t=%0t", intId, c, $time);
      end
      nChecks++;
      if (irq !== eIrq) begin
        nFails++;
        $display("FAIL R2 model irq actual=%0b expected=%0b t=%0t", irq, eIrq, $time);
      end
      nChecks++;
      if (int'(modemDelta) != mDelta) begin
        nFails++;
        $display("FAIL R7 model modemDelta actual=%0h expected=%0h t=%0t", modemDelta, mDelta, $time);
      end
      nThr   = thrEmptyEvt || (mThr && !thrWrite && !(idRead && c == 'h02));
      nSpc   = specialEvt || (mSpc && !(idRead && c == 'h10));
      nFlow  = flowEvt || (mFlow && !(idRead && c == 'h20));
      nDelta = int'(modemEvt) | (msrRead ? 0 : mDelta);
    end
  end

  always @(posedge clk) begin
    if (!rstN) begin
      mThr <= 0; mSpc <= 0; mFlow <= 0; mDelta <= 0;
    end else begin
      mThr <= nThr; mSpc <= nSpc; mFlow <= nFlow; mDelta <= nDelta;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string tag, logic [5:0] eId, logic eIrq, logic [MDM_W-1:0] eDelta);
    @(negedge clk); #1;
    nChecks++;
    if (intId !== eId || irq !== eIrq || modemDelta !== eDelta) begin
      nFails++;
      $display("FAIL %s actual id=%02h irq=%0b delta=%0h expected id=%02h irq=%0b delta=%0h",
               tag, intId, irq, modemDelta, eId, eIrq, eDelta);
    end
    step();
  endtask

  initial begin
    step(); step();
    chk("R1 during reset", 6'h01, 0, 4'h0);
    rstN = 1;
    chk("R1 after reset", 6'h01, 0, 4'h0);
    intEnable = 6'h3F;
    lineErr = 1;
    chk("R3 line code", 6'h06, 1, 4'h0);
    lineErr = 0;
    chk("R11 line not latched", 6'h01, 0, 4'h0);
    rxTrig = 1;
    chk("R3 rx data code", 6'h04, 1, 4'h0);
    rxTimeout = 1;
    chk("R4 timeout over rx", 6'h0C, 1, 4'h0);
    lineErr = 1;
    chk("R4 line over timeout", 6'h06, 1, 4'h0);
    lineErr = 0; rxTimeout = 0; rxTrig = 0;
    chk("R11 levels released", 6'h01, 0, 4'h0);
    thrEmptyEvt = 1; step(); thrEmptyEvt = 0;
    chk("R6 tx empty set", 6'h02, 1, 4'h0);
    specialEvt = 1; step(); specialEvt = 0;
    chk("R4 tx empty over special", 6'h02, 1, 4'h0);
    idRead = 1; step(); idRead = 0;
    chk("R6 R10 read clears tx only", 6'h10, 1, 4'h0);
    idRead = 1; step(); idRead = 0;
    chk("R8 special cleared", 6'h01, 0, 4'h0);
    flowEvt = 1; step(); flowEvt = 0;
    chk("R3 flow code", 6'h20, 1, 4'h0);
    lineErr = 1;
    chk("R4 line over flow", 6'h06, 1, 4'h0);
    idRead = 1; step(); idRead = 0; lineErr = 0;
    chk("R10 flow kept after line read", 6'h20, 1, 4'h0);
    idRead = 1; step(); idRead = 0;
    chk("R9 flow cleared", 6'h01, 0, 4'h0);
    modemEvt = 4'h4; step(); modemEvt = '0;
    chk("R7 modem set", 6'h00, 1, 4'h4);
    idRead = 1; step(); idRead = 0;
    chk("R10 id read leaves modem", 6'h00, 1, 4'h4);
    msrRead = 1; step(); msrRead = 0;
    chk("R7 modem cleared", 6'h01, 0, 4'h0);
    intEnable = 6'h3E; rxTrig = 1;
    chk("R5 rx disabled", 6'h01, 0, 4'h0);
    intEnable = 6'h3F;
    chk("R5 rx enabled", 6'h04, 1, 4'h0);
    rxTrig = 0; intEnable = 6'h3D;
    thrEmptyEvt = 1; step(); thrEmptyEvt = 0;
    chk("R5 tx masked", 6'h01, 0, 4'h0);
    intEnable = 6'h3F;
    chk("R5 tx kept while masked", 6'h02, 1, 4'h0);
    thrWrite = 1; step(); thrWrite = 0;
    chk("R6 thr write clears", 6'h01, 0, 4'h0);
    thrEmptyEvt = 1; thrWrite = 1; step(); thrEmptyEvt = 0; thrWrite = 0;
    chk("R12 tx set wins", 6'h02, 1, 4'h0);
    thrWrite = 1; step(); thrWrite = 0;
    chk("R6 cleared again", 6'h01, 0, 4'h0);
    modemEvt = 4'h1; step(); modemEvt = 4'h2; msrRead = 1; step(); modemEvt = '0; msrRead = 0;
    chk("R12 modem set wins", 6'h00, 1, 4'h2);
    msrRead = 1; step(); msrRead = 0;
    chk("R7 modem cleared again", 6'h01, 0, 4'h0);
    specialEvt = 1; flowEvt = 1; thrEmptyEvt = 1; step();
    specialEvt = 0; flowEvt = 0; thrEmptyEvt = 0;
    intEnable = 6'h10;
    chk("R5 only special enabled", 6'h10, 1, 4'h0);
    idRead = 1; step(); idRead = 0;
    intEnable = 6'h3F;
    chk("R10 tx survives special read", 6'h02, 1, 4'h0);
    specialEvt = 1; idRead = 1; intEnable = 6'h10; step();
    specialEvt = 0; idRead = 0;
    chk("R12 special set wins over read", 6'h10, 1, 4'h0);
    intEnable = 6'h3F;
    step(); step();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule